// File: doc/BRIEF.md
# Strobe-Order Refresh Scheduler

This block keeps a DRAM array alive by issuing refresh cycles in which the column strobes go low before the row strobe. Because the memory supplies the row address from its own internal counter, no address is driven. A free-running interval timer adds one owed refresh every `INTERVAL` clock cycles. The count of owed refreshes is kept so that a busy access controller can defer several of them and then let them run as a burst.

The block shares the DRAM bus with the access controller through a request/grant handshake. `ref_req` stays high while any refresh is owed. `ref_urgent` tells the controller that the owed count has reached a threshold and the bus should be handed over soon. The scheduler drives the row strobe and both column strobes only while `bus_own` is high. The outer bus multiplexer uses `bus_own` to choose between the scheduler's strobes and the controller's.

In a burst, the column strobes stay low through each precharge, and only the row strobe toggles. All timing values are whole clock cycles, set by parameters.

Top module: `cbr_refresh_sched`

## Requirements
- R1: After reset the interval timer starts at zero. One refresh becomes owed at each `INTERVAL`-th clock edge. `ref_req` is high exactly while the owed count is non-zero, and each completed row-strobe pulse retires one owed refresh.
- R2: A refresh that does not follow another in the same ownership first drives both column strobes low with the row strobe high for exactly `T_CSR` cycles. Only then does the row strobe fall.
- R3: Both column strobes stay low for every cycle in which the row strobe is low.
- R4: Each row-strobe low pulse lasts exactly `T_RAS` cycles.
- R5: After each pulse the row strobe stays high for at least `T_RP` cycles before it can fall again. Between chained refreshes this gap is exactly `T_RP` cycles, and the column strobes stay low throughout it.
- R6: The owed count saturates at `MAX_PEND`. A tick that arrives while the count is saturated is lost.
- R7: `ref_urgent` is high exactly while the owed count is at least `URGENT_TH`.
- R8: `bus_own` rises only in the cycle after a cycle in which `ref_grant` was high and a refresh was owed. While `bus_own` is low, the row strobe and both column strobes are high. While `bus_own` is high, the write enable and output enable (both active low) are high.
- R9: At the end of a row-strobe pulse, the block chains into another refresh only if a refresh is still owed and `ref_grant` is high in that cycle. Otherwise it raises the column strobes together with the row strobe, finishes the precharge and releases the bus.
- R10: During reset all strobes are high and `ref_req`, `ref_urgent` and `bus_own` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Access controller hands the DRAM bus to the scheduler |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed count has reached `URGENT_TH` |
| bus_own | output | 1 | Scheduler is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| oe_n | output | 1 | Output enable, active low, held high |

## Verification
The assertions assume that `ref_grant` is a level that the controller raises only when it has released the bus. The controller may drop it at any time. They also assume `T_RP >= T_CSR`, so that a chained refresh keeps a valid strobe lead. The stimulus changes `ref_grant` only on falling clock edges. It schedules each grant change at a known clock count relative to the interval ticks, so that no tick lands inside a burst except where a case deliberately checks that. It also drops the grant in the middle of a refresh to exercise the chaining decision.

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int INTERVAL  = 1950,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 18,
  parameter int T_RP      = 13,
  parameter int MAX_PEND  = 8,
  parameter int URGENT_TH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int IW   = $clog2(INTERVAL);
  localparam int PW   = $clog2(MAX_PEND + 1);
  localparam int TMAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                       : ((T_RP > T_CSR) ? T_RP : T_CSR);
  localparam int TW   = $clog2(TMAX + 2);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_ACT, S_PRE} st_t;

  st_t           st;
  logic [IW-1:0] tmr;
  logic [PW-1:0] pend, pend_nx;
  logic [TW-1:0] tcnt;
  logic          chain;
  logic          tick, done, cas_low;

  assign tick = (tmr == IW'(INTERVAL - 1));
  assign done = (st == S_ACT) && (tcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tick ? '0 : tmr + 1'b1;
  end

  always_comb begin
    pend_nx = pend;
    if (tick && !done && pend != PW'(MAX_PEND)) pend_nx = pend + 1'b1;
    else if (done && !tick)                     pend_nx = pend - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tcnt  <= '0;
      chain <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (ref_req && ref_grant) begin
            st   <= S_LEAD;
            tcnt <= TW'(T_CSR - 1);
          end
        S_LEAD:
          if (tcnt == '0) begin
            st   <= S_ACT;
            tcnt <= TW'(T_RAS - 1);
          end else tcnt <= tcnt - 1'b1;
        S_ACT:
          if (tcnt == '0) begin
            st    <= S_PRE;
            tcnt  <= TW'(T_RP - 1);
            chain <= (pend_nx != '0) && ref_grant;
          end else tcnt <= tcnt - 1'b1;
        default:
          if (tcnt == '0) begin
            st    <= chain ? S_ACT : S_IDLE;
            tcnt  <= TW'(T_RAS - 1);
            chain <= 1'b0;
          end else tcnt <= tcnt - 1'b1;
      endcase
    end
  end

  assign cas_low    = (st == S_LEAD) || (st == S_ACT) || (st == S_PRE && chain);
  assign ras_n      = (st != S_ACT);
  assign lcas_n     = !cas_low;
  assign ucas_n     = !cas_low;
  assign we_n       = 1'b1;
  assign oe_n       = 1'b1;
  assign bus_own    = (st != S_IDLE);
  assign ref_req    = (pend != '0);
  assign ref_urgent = (pend >= PW'(URGENT_TH));

  logic [TW-1:0] lo_len, hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= TW'(T_RP);
    end else begin
      lo_len <= ras_n ? '0 : ((lo_len == TW'(TMAX + 1)) ? lo_len : lo_len + 1'b1);
      hi_len <= !ras_n ? '0 : ((hi_len == TW'(T_RP)) ? hi_len : hi_len + 1'b1);
    end
  end

  assert_cbr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!lcas_n && !ucas_n));
  assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!lcas_n && !ucas_n));
  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_len == TW'(T_RAS)));
  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_len == TW'(T_RP)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done && pend == PW'(MAX_PEND)) |=> (pend == PW'(MAX_PEND)));
  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && lcas_n && ucas_n));
  assert_grant_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(ref_grant && ref_req));
endmodule

// File: tb/test_cbr_refresh_sched.sv
module test_cbr_refresh_sched;
  localparam int INTERVAL = 100, T_CSR = 2, T_RAS = 4, T_RP = 3, MAX_PEND = 8, URGENT_TH = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_grant = 1'b0;
  logic ref_req, ref_urgent, bus_own, ras_n, lcas_n, ucas_n, we_n, oe_n;

  always #2 clk = ~clk;

  cbr_refresh_sched #(.INTERVAL(INTERVAL), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .MAX_PEND(MAX_PEND), .URGENT_TH(URGENT_TH)) i_cbr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .bus_own(bus_own), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n));

  int checks = 0, errors = 0, cyc = 0, seen = 0, viol = 0;
  int exp_q[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push_burst(input int n);
    exp_q.push_back(T_CSR);
    for (int i = 1; i < n; i++) exp_q.push_back(T_RP);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  logic prev_ras = 1'b1;
  int lead = 0, lo_len = 0;
  bit cas_broke = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!ras_n || !lcas_n || !ucas_n) && !bus_own) viol++;
      if (bus_own && (!we_n || !oe_n)) viol++;
      if (prev_ras && !ras_n) begin
        seen++;
        if (exp_q.size() == 0) chk(0, "R1 unexpected refresh", lead, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(lead == e, (e == T_CSR) ? "R2 strobe lead" : "R5/R9 chained gap", lead, e);
        end
        cas_broke = 0;
      end
      if (!prev_ras && ras_n) begin
        chk(lo_len == T_RAS, "R4 row pulse width", lo_len, T_RAS);
        chk(!cas_broke, "R3 column strobes held", cas_broke, 0);
      end
      if (ras_n) begin
        lo_len = 0;
        lead = (!lcas_n && !ucas_n) ? lead + 1 : 0;
      end else begin
        lo_len++;
        lead = 0;
        if (lcas_n || ucas_n) cas_broke = 1;
      end
      prev_ras = ras_n;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R10 strobes idle", ras_n, 1);
    chk(!ref_req && !ref_urgent && !bus_own, "R10 flags low", ref_req, 0);
    rst_n = 1'b1;
    wait_cyc(99);
    chk(!ref_req, "R1 no tick before interval", ref_req, 0);
    wait_cyc(101);
    chk(ref_req, "R1 first tick", ref_req, 1);
    wait_cyc(399);
    chk(!ref_urgent, "R7 below threshold", ref_urgent, 0);
    chk(ras_n && !bus_own, "R8 no grant no activity", bus_own, 0);
    wait_cyc(405);
    chk(ref_urgent, "R7 at threshold", ref_urgent, 1);
    push_burst(4);
    ref_grant = 1'b1;
    wait_cyc(460);
    chk(!ref_urgent && !ref_req && !bus_own, "R1 burst retired", ref_req, 0);
    chk(exp_q.size() == 0, "R9 burst length", exp_q.size(), 0);
    exp_q.push_back(T_CSR); exp_q.push_back(T_CSR); exp_q.push_back(T_CSR);
    wait_cyc(760);
    chk(exp_q.size() == 0, "R1 one refresh per interval", exp_q.size(), 0);
    ref_grant = 1'b0;
    wait_cyc(1705);
    chk(ref_urgent && ref_req, "R7 saturated urgent", ref_urgent, 1);
    push_burst(MAX_PEND);
    ref_grant = 1'b1;
    wait_cyc(1790);
    chk(!ref_req, "R6 saturation drained", ref_req, 0);
    chk(exp_q.size() == 0, "R6 saturated burst", exp_q.size(), 0);
    ref_grant = 1'b0;
    wait_cyc(2005);
    exp_q.push_back(T_CSR);
    ref_grant = 1'b1;
    wait_cyc(2009);
    ref_grant = 1'b0;
    wait_cyc(2030);
    chk(ref_req && !bus_own, "R9 released on grant loss", bus_own, 0);
    chk(ras_n && lcas_n && ucas_n, "R9 strobes released", lcas_n, 1);
    push_burst(2);
    ref_grant = 1'b1;
    wait_cyc(2080);
    chk(!ref_req && exp_q.size() == 0, "R9 remainder done", exp_q.size(), 0);
    chk(seen == 18, "R1 total refreshes", seen, 18);
    chk(viol == 0, "R8 bus ownership", viol, 0);
    summary();
  end
endmodule